// File: doc/BRIEF.md
# Post-Update Load Execution Unit

This block executes the load-with-post-update operations of a 64-bit load/store pipeline. A decoded operation arrives with the base register value, either an index register value or a 16-bit immediate, an access size and an algebraic (sign-extend) flag. The block sends the base value, unchanged, to memory as the access address. It waits for the single response. It then returns two register writebacks in one cycle: the formatted loaded value for the target register, and base plus offset for the base register.

The register numbers of an operation are checked before any access starts. A base register number of zero, or a base register equal to the target register, makes the operation invalid. The block then raises a one-cycle invalid-form flag, issues no memory request and performs no writeback. Only one load is in flight at a time. The operation input and the memory request each use a valid/ready handshake. The memory response is a plain valid with 64-bit little-endian data, and the requested bytes sit in its low-order lanes.

Top module: `pu_load_unit`

## Requirements
- R1: `mem_req_addr` equals the accepted `op_base` with nothing added, and address and valid stay unchanged while `mem_req_ready` is low.
- R2: For displacement forms of sizes 0 to 2, `wb_ra_data` is `op_base` plus the sign-extended 16-bit `op_imm`, taken modulo 2^64.
- R3: For indexed forms (`op_indexed`=1), `wb_ra_data` is `op_base` plus `op_index`, taken modulo 2^64, and `op_imm` has no effect.
- R4: For the doubleword displacement form (size 3), bits [1:0] of `op_imm` are ignored. The offset is the sign extension of `op_imm[15:2]` followed by two zero bits.
- R5: Size codes 0, 1 and 2 select 8, 16 and 32 bits from the low end of `mem_rsp_data`. Without the algebraic flag, all higher bits of `wb_rt_data` are zero.
- R6: With `op_algebraic`=1, halfword and word results are sign-extended to 64 bits. The flag has no effect for size 0 (zero-extended byte) or size 3 (all 64 bits returned).
- R7: An operation with `op_ra`=0 or `op_ra`=`op_rt` is accepted. It makes `bad_form` high for exactly the cycle after acceptance, and causes no memory request and no writeback.
- R8: `wb_valid` is high for exactly one cycle, the cycle after the response handshake. It carries both `wb_rt_*` and `wb_ra_*`, and stays low while the request or the response stalls.
- R9: `op_ready` is low from the acceptance of a legal operation until the response is taken, so only one load is outstanding.
- R10: After reset, `op_ready`=1 and `mem_req_valid`, `wb_valid` and `bad_form` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block can accept an operation |
| op_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_algebraic | input | 1 | Sign-extend the loaded value |
| op_indexed | input | 1 | Offset is `op_index` rather than `op_imm` |
| op_rt | input | RIDX_W | Target register number |
| op_ra | input | RIDX_W | Base register number |
| op_base | input | XLEN | Base register value |
| op_index | input | XLEN | Index register value |
| op_imm | input | IMM_W | Immediate displacement field |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | XLEN | Access address |
| mem_req_size | output | 2 | Access size code |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | XLEN | Response data, little-endian |
| wb_valid | output | 1 | Both writebacks valid |
| wb_rt_idx | output | RIDX_W | Target register number |
| wb_rt_data | output | XLEN | Formatted load result |
| wb_ra_idx | output | RIDX_W | Base register number |
| wb_ra_data | output | XLEN | Updated base value |
| bad_form | output | 1 | Invalid register combination seen |

## Verification
The bench builds the block with its defaults: XLEN=64, RIDX_W=5 and IMM_W=16. With these values all sixteen combinations of size, algebraic flag and offset form can be swept, each with three data, base and offset patterns. The patterns include lane data with the sign bit set and clear, negative immediates with the low two bits set, and base updates that wrap past 2^64 in both directions. Request and response stalls vary across the sweep. Both illegal register cases are driven, along with the case where both register numbers are zero.

// File: rtl/pu_load_pkg.sv
package pu_load_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lsu_state_e;

  typedef struct packed {
    acc_size_e size;
    logic      algebraic;
  } ld_ctl_t;

  function automatic int unsigned size_bits(acc_size_e s);
    return 8 << s;
  endfunction

endpackage

// File: rtl/pu_form_chk.sv
module pu_form_chk #(
  parameter int RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] ra,
  input  logic [RIDX_W-1:0] rt,
  output logic              illegal
);
  logic ra_zero;
  logic ra_eq_rt;

  assign ra_zero  = (ra == '0);
  assign ra_eq_rt = (ra == rt);
  assign illegal  = ra_zero || ra_eq_rt;
endmodule

// File: rtl/pu_offset_gen.sv
module pu_offset_gen
  import pu_load_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic             indexed,
  input  acc_size_e        size,
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  index,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  new_base
);
  localparam int EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] disp_offset(logic [IMM_W-1:0] f, acc_size_e s);
    logic [IMM_W-1:0] eff;
    eff = f;
    if (s == SZ_DBL) eff[1:0] = 2'b00;
    return {{EXT_W{eff[IMM_W-1]}}, eff};
  endfunction

  logic [XLEN-1:0] offset;

  assign offset   = indexed ? index : disp_offset(imm, size);
  assign new_base = base + offset;
endmodule

// File: rtl/pu_data_fmt.sv
module pu_data_fmt
  import pu_load_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  acc_size_e       size,
  input  logic            algebraic,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] result
);
  function automatic logic [XLEN-1:0] lane_mask(acc_size_e s);
    return {XLEN{1'b1}} >> (XLEN - int'(size_bits(s)));
  endfunction

  function automatic logic lane_sign(acc_size_e s, logic [XLEN-1:0] d);
    return d[size_bits(s) - 1];
  endfunction

  logic [XLEN-1:0] mask;
  logic            do_sext;
  logic            sign;

  assign mask    = lane_mask(size);
  assign do_sext = algebraic && ((size == SZ_HALF) || (size == SZ_WORD));
  assign sign    = lane_sign(size, raw);
  assign result  = (raw & mask) | ((do_sext && sign) ? ~mask : '0);
endmodule

// File: rtl/pu_load_unit.sv
module pu_load_unit
  import pu_load_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RIDX_W = 5,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_algebraic,
  input  logic              op_indexed,
  input  logic [RIDX_W-1:0] op_rt,
  input  logic [RIDX_W-1:0] op_ra,
  input  logic [XLEN-1:0]   op_base,
  input  logic [XLEN-1:0]   op_index,
  input  logic [IMM_W-1:0]  op_imm,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [1:0]        mem_req_size,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_rt_idx,
  output logic [XLEN-1:0]   wb_rt_data,
  output logic [RIDX_W-1:0] wb_ra_idx,
  output logic [XLEN-1:0]   wb_ra_data,
  output logic              bad_form
);
  lsu_state_e        st;
  ld_ctl_t           cap_ctl;
  logic [XLEN-1:0]   cap_base;
  logic [XLEN-1:0]   cap_new_base;
  logic [RIDX_W-1:0] cap_rt;
  logic [RIDX_W-1:0] cap_ra;

  // named internal events
  logic            op_fire;
  logic            op_illegal;
  logic            accept_legal;
  logic            accept_bad;
  logic            req_fire;
  logic            rsp_fire;
  logic [XLEN-1:0] upd_base;
  logic [XLEN-1:0] fmt_data;
  acc_size_e       in_size;

  assign in_size      = acc_size_e'(op_size);
  assign op_ready     = (st == ST_IDLE);
  assign op_fire      = op_valid && op_ready;
  assign accept_legal = op_fire && !op_illegal;
  assign accept_bad   = op_fire && op_illegal;
  assign mem_req_valid = (st == ST_REQ);
  assign req_fire     = mem_req_valid && mem_req_ready;
  assign rsp_fire     = (st == ST_WAIT) && mem_rsp_valid;
  assign mem_req_addr = cap_base;
  assign mem_req_size = cap_ctl.size;

  pu_form_chk #(.RIDX_W(RIDX_W)) u_chk (
    .ra      (op_ra),
    .rt      (op_rt),
    .illegal (op_illegal)
  );

  pu_offset_gen #(.XLEN(XLEN), .IMM_W(IMM_W)) u_off (
    .indexed  (op_indexed),
    .size     (in_size),
    .base     (op_base),
    .index    (op_index),
    .imm      (op_imm),
    .new_base (upd_base)
  );

  pu_data_fmt #(.XLEN(XLEN)) u_fmt (
    .size      (cap_ctl.size),
    .algebraic (cap_ctl.algebraic),
    .raw       (mem_rsp_data),
    .result    (fmt_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (accept_legal) st <= ST_REQ;
        ST_REQ:  if (req_fire)     st <= ST_WAIT;
        ST_WAIT: if (rsp_fire)     st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ctl      <= '0;
      cap_base     <= '0;
      cap_new_base <= '0;
      cap_rt       <= '0;
      cap_ra       <= '0;
    end else if (accept_legal) begin
      cap_ctl      <= '{size: in_size, algebraic: op_algebraic};
      cap_base     <= op_base;
      cap_new_base <= upd_base;
      cap_rt       <= op_rt;
      cap_ra       <= op_ra;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid   <= 1'b0;
      wb_rt_idx  <= '0;
      wb_rt_data <= '0;
      wb_ra_idx  <= '0;
      wb_ra_data <= '0;
      bad_form   <= 1'b0;
    end else begin
      wb_valid <= rsp_fire;
      bad_form <= accept_bad;
      if (rsp_fire) begin
        wb_rt_idx  <= cap_rt;
        wb_rt_data <= fmt_data;
        wb_ra_idx  <= cap_ra;
        wb_ra_data <= cap_new_base;
      end
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> !wb_valid && !mem_req_valid);

  // R7
  wb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_ra_idx != '0) && (wb_ra_idx != wb_rt_idx));

  // R8
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R9
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || st == ST_WAIT) |-> !op_ready);

  // R5
  byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && cap_ctl.size == SZ_BYTE |-> wb_rt_data[XLEN-1:8] == '0);

  // R6
  half_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && cap_ctl.size == SZ_HALF && cap_ctl.algebraic
      |-> (&wb_rt_data[XLEN-1:15]) || !(|wb_rt_data[XLEN-1:15]));

  // R8
  wb_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> wb_valid);
endmodule

// File: tb/tb_pu_load_unit.sv
`timescale 1ns/1ps
module tb_pu_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_algebraic = 1'b0;
  logic        op_indexed = 1'b0;
  logic [4:0]  op_rt = '0;
  logic [4:0]  op_ra = '0;
  logic [63:0] op_base = '0;
  logic [63:0] op_index = '0;
  logic [15:0] op_imm = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        wb_valid;
  logic [4:0]  wb_rt_idx;
  logic [63:0] wb_rt_data;
  logic [4:0]  wb_ra_idx;
  logic [63:0] wb_ra_data;
  logic        bad_form;

  int nchecks = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  pu_load_unit dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_rt(int sz, bit alg, logic [63:0] d);
    int sh;
    logic [63:0] t;
    sh = 64 - (8 << sz);
    t = d << sh;
    if (sz == 3) return d;
    if (alg && sz != 0) return $signed(t) >>> sh;
    return t >> sh;
  endfunction

  function automatic logic [63:0] ref_ra(int sz, bit ix, logic [63:0] b,
                                         logic [63:0] x, logic [15:0] imm);
    longint off;
    if (ix) return b + x;
    off = longint'($signed(imm));
    if (sz == 3) off = off & ~longint'(3);
    return b + 64'(off);
  endfunction

  task automatic run_load(int sz, bit alg, bit ix, logic [4:0] rt, logic [4:0] ra,
                          logic [63:0] b, logic [63:0] x, logic [15:0] imm,
                          logic [63:0] d, int req_stall, int rsp_stall);
    string rtag, atag;
    rtag = (alg && (sz == 1 || sz == 2)) ? "R6" : ((sz == 3 && alg) ? "R6" : "R5");
    atag = ix ? "R3" : ((sz == 3) ? "R4" : "R2");
    @(negedge clk);
    chk("R9 ready idle", 64'(op_ready), 64'd1);
    op_valid = 1'b1; op_size = 2'(sz); op_algebraic = alg; op_indexed = ix;
    op_rt = rt; op_ra = ra; op_base = b; op_index = x; op_imm = imm;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; op_base = ~b; op_index = ~x; op_imm = ~imm;
    chk("R1 req valid", 64'(mem_req_valid), 64'd1);
    chk("R1 addr", mem_req_addr, b);
    chk("R9 busy", 64'(op_ready), 64'd0);
    for (int i = 0; i < req_stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R1 held", mem_req_addr, b);
      chk("R8 no wb on req stall", 64'(wb_valid), 64'd0);
    end
    mem_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R9 one req", 64'(mem_req_valid), 64'd0);
    for (int i = 0; i < rsp_stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R8 no wb on rsp stall", 64'(wb_valid), 64'd0);
      chk("R9 busy in wait", 64'(op_ready), 64'd0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(posedge clk); @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 64'hDEAD_BEEF_0BAD_F00D;
    chk("R8 wb valid", 64'(wb_valid), 64'd1);
    chk({rtag, " rt data"}, wb_rt_data, ref_rt(sz, alg, d));
    chk({atag, " ra data"}, wb_ra_data, ref_ra(sz, ix, b, x, imm));
    chk("R8 rt idx", 64'(wb_rt_idx), 64'(rt));
    chk("R8 ra idx", 64'(wb_ra_idx), 64'(ra));
    @(posedge clk); @(negedge clk);
    chk("R8 single pulse", 64'(wb_valid), 64'd0);
  endtask

  task automatic run_bad(logic [4:0] rt, logic [4:0] ra);
    @(negedge clk);
    op_valid = 1'b1; op_rt = rt; op_ra = ra; op_size = 2'd2;
    op_indexed = 1'b1; op_base = 64'h1000; op_index = 64'h8;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk("R7 flag", 64'(bad_form), 64'd1);
    chk("R7 no req", 64'(mem_req_valid), 64'd0);
    chk("R7 ready", 64'(op_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    chk("R7 flag pulse", 64'(bad_form), 64'd0);
    chk("R7 no wb", 64'(wb_valid), 64'd0);
    chk("R7 still no req", 64'(mem_req_valid), 64'd0);
  endtask

  initial begin
    logic [63:0] dat [3];
    logic [63:0] bas [3];
    logic [63:0] idx [3];
    logic [15:0] imv [3];
    dat[0] = 64'h8899_AABB_CCDD_EEFF;
    dat[1] = 64'h0123_4567_7654_3210;
    dat[2] = 64'hFEDC_BA98_0192_8374;
    bas[0] = 64'h0000_0000_0000_0008;
    bas[1] = 64'hFFFF_FFFF_FFFF_FFF0;
    bas[2] = 64'h0000_1234_5678_9ABC;
    idx[0] = 64'hFFFF_FFFF_FFFF_FFE0;
    idx[1] = 64'h0000_0000_0000_0020;
    idx[2] = 64'h0000_0000_0001_0000;
    imv[0] = 16'hFFF1;
    imv[1] = 16'h7FFE;
    imv[2] = 16'h8003;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 op_ready", 64'(op_ready), 64'd1);
    chk("R10 req", 64'(mem_req_valid), 64'd0);
    chk("R10 wb", 64'(wb_valid), 64'd0);
    chk("R10 bad", 64'(bad_form), 64'd0);
    rst_n = 1'b1;

    for (int sz = 0; sz < 4; sz++)
      for (int alg = 0; alg < 2; alg++)
        for (int ix = 0; ix < 2; ix++)
          for (int p = 0; p < 3; p++)
            run_load(sz, alg[0], ix[0], 5'(1 + p), 5'(8 + sz), bas[p], idx[p],
                     imv[p], dat[p], (p + sz) % 3, (p + ix + alg) % 4);

    run_bad(5'd4, 5'd0);
    run_bad(5'd9, 5'd9);
    run_bad(5'd0, 5'd0);
    run_load(2, 1'b0, 1'b0, 5'd2, 5'd31, 64'h10, 64'h0, 16'h0004, dat[0], 0, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule